// File: doc/BRIEF.md
# Four-way set-associative data cache controller

This block sits between a 32-bit processor load/store port and a word-wide memory bus. It holds 8 KB of data in 128 sets of four ways, with 16-byte (four-word) lines. A load that hits returns its word in the cycle it is presented. A miss picks a victim way, writes that line back if it is dirty, and refills the line from memory one word at a time. The load is then answered from the refilled line.

Each store carries its own policy bit. A write-back store keeps the new data in the cache and marks the line dirty. A write-through store updates the cache on a hit and always queues the word for memory. All memory writes, including victim write-backs, pass through a four-entry in-order write queue. A refill never starts while that queue still holds a word of the line being fetched. A one-cycle invalidate pulse clears every line in one pass over the sets, and the processor waits until the pass ends.

The processor holds `cpu_req` and its operands steady until `cpu_ready` pulses for one cycle. The memory side has two channels. On the read channel, `mem_rd_valid` answers the request for the address currently shown. On the write channel, `mem_wr_ack` takes the word at the head of the queue.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is invalid, no memory request is driven and `cpu_ready` is low, so the first load to any address misses.
- R2: Address bits [3:2] pick the word in the line, [10:4] pick the set and [31:11] form the tag. A load that hits is answered with `cpu_ready` in the cycle it is presented, without any memory read.
- R3: On a load miss, four memory reads are issued to the line base plus 0, 4, 8 and 12, in that order. The requested word is then returned.
- R4: The victim is the lowest-numbered invalid way of the set. If no way is invalid, a 3-bit tree pseudo-LRU chooses it. Root bit 0 points at pair {0,1} or pair {2,3}. Bit 1 picks within {0,1} and bit 2 picks within {2,3}. Every hit and every fill sets these bits to point away from the way that was used.
- R5: A write-back store that hits updates the cached word and marks the line dirty. It causes no memory write.
- R6: A write-back store that misses allocates the line (refill), then writes the word as a dirty hit. No memory write occurs.
- R7: A dirty victim is queued as four words, in offset order 0, 4, 8, 12, before its replacement is fetched.
- R8: A write-through store queues exactly one memory write. On a hit it also updates the cache. On a miss it does not allocate a line.
- R9: The write queue holds up to four words and sends them in arrival order. A store that needs a full queue stalls. The head address and data stay stable until `mem_wr_ack`.
- R10: A refill starts only when the write queue holds no word whose address bits [31:4] match the missing line. A load after a queued store to the same line therefore sees the stored data.
- R11: A `cpu_inval` pulse clears every valid and dirty bit in one pass over the 128 sets, and dirty data is discarded rather than written. No request is answered until the pass ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_wt | input | 1 | Store policy: 1 = write-through, 0 = write-back |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_inval | input | 1 | One-cycle pulse: invalidate the whole cache |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion of the held request |
| mem_rd_req | output | 1 | Refill read request |
| mem_rd_addr | output | 32 | Refill word address |
| mem_rd_valid | input | 1 | Read data valid for the shown address |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Write queue not empty |
| mem_wr_addr | output | 32 | Head word address |
| mem_wr_data | output | 32 | Head word data |
| mem_wr_ack | input | 1 | Head word accepted |

## Verification
A wrong tag, valid or pseudo-LRU bit shows up at the ports as a refill where a hit was due, or a hit where a refill was due. The bench counts refill beats for every access, so such a fault appears on the very next access to the affected set. A lost dirty bit or a misordered queue shows up as a missing or out-of-order word on the write channel, which the write scoreboard catches as the word leaves. A refill that overtakes a queued store returns stale data on the load that follows it.

// File: rtl/dcache_ctrl.sv
module dcache_ctrl #(
  parameter int SET_BITS = 7,
  parameter int WB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic        cpu_wt,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic        cpu_inval,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        mem_wr_req,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_ack
);
  localparam int SETS  = 2 ** SET_BITS;
  localparam int TAG_W = 28 - SET_BITS;
  localparam int PW    = $clog2(WB_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_WAIT, S_FILL, S_INVAL} st_t;
  st_t st;

  logic [TAG_W-1:0] tags [SETS][4];
  logic [31:0]      dmem [SETS][4][4];
  logic [3:0]       vld  [SETS];
  logic [3:0]       drt  [SETS];
  logic [2:0]       plru [SETS];

  logic [31:0]   fa [WB_DEPTH];
  logic [31:0]   fd [WB_DEPTH];
  logic [PW-1:0] rp, wp;
  logic [PW:0]   fcnt;

  logic [1:0] cnt, vway, vict, hway;
  logic [SET_BITS-1:0] icnt;
  logic inval_pend, push, conflict;
  logic [31:0] push_a, push_d;
  logic [3:0] hitv;

  wire [SET_BITS-1:0] set  = cpu_addr[4 +: SET_BITS];
  wire [TAG_W-1:0]    tag  = cpu_addr[31 -: TAG_W];
  wire [1:0]          wsel = cpu_addr[3:2];
  wire unused_lo = ^cpu_addr[1:0];
  wire hit  = |hitv;
  wire full = (fcnt == (PW+1)'(WB_DEPTH));
  wire pop  = mem_wr_req & mem_wr_ack;
  wire wt_st = cpu_we & cpu_wt;

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] w);
    touch = p;
    touch[0] = ~w[1];
    if (!w[1]) touch[1] = ~w[0];
    else       touch[2] = ~w[0];
  endfunction

  always_comb begin
    for (int w = 0; w < 4; w++) hitv[w] = vld[set][w] && (tags[set][w] == tag);
  end
  assign hway = {hitv[3] | hitv[2], hitv[3] | hitv[1]};

  always_comb begin
    vict = plru[set][0] ? {1'b1, plru[set][2]} : {1'b0, plru[set][1]};
    for (int w = 3; w >= 0; w--) if (!vld[set][w]) vict = 2'(w);
  end

  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < WB_DEPTH; i++)
      if (({1'b0, PW'(i) - rp} < fcnt) && (fa[i][31:4] == cpu_addr[31:4])) conflict = 1'b1;
  end

  always_comb begin
    cpu_ready = 1'b0;
    push      = 1'b0;
    push_a    = {cpu_addr[31:2], 2'b00};
    push_d    = cpu_wdata;
    if (st == S_IDLE && !inval_pend && cpu_req) begin
      if (wt_st) begin
        push      = !full;
        cpu_ready = !full;
      end else begin
        cpu_ready = hit;
      end
    end else if (st == S_EVICT) begin
      push   = !full;
      push_a = {tags[set][vway], set, cnt, 2'b00};
      push_d = dmem[set][vway][cnt];
    end
  end

  assign cpu_rdata   = dmem[set][hway][wsel];
  assign mem_rd_req  = (st == S_FILL);
  assign mem_rd_addr = {cpu_addr[31:4], cnt, 2'b00};
  assign mem_wr_req  = (fcnt != '0);
  assign mem_wr_addr = fa[rp];
  assign mem_wr_data = fd[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      inval_pend <= 1'b0;
      cnt <= '0;
      vway <= '0;
      icnt <= '0;
      rp <= '0;
      wp <= '0;
      fcnt <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        drt[s]  <= '0;
        plru[s] <= '0;
      end
    end else begin
      wp   <= wp + PW'(push);
      rp   <= rp + PW'(pop);
      fcnt <= fcnt + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};
      case (st)
        S_IDLE:
          if (inval_pend) begin
            st <= S_INVAL;
            icnt <= '0;
          end else if (cpu_req) begin
            if (cpu_ready && hit) begin
              plru[set] <= touch(plru[set], hway);
              if (cpu_we && !cpu_wt) drt[set][hway] <= 1'b1;
            end else if (!hit && !wt_st) begin
              vway <= vict;
              cnt  <= '0;
              st   <= (vld[set][vict] && drt[set][vict]) ? S_EVICT : S_WAIT;
            end
          end
        S_EVICT:
          if (!full) begin
            cnt <= cnt + 2'd1;
            if (cnt == 2'd3) begin
              st <= S_WAIT;
              vld[set][vway] <= 1'b0;
              drt[set][vway] <= 1'b0;
            end
          end
        S_WAIT:
          if (!conflict) begin
            st  <= S_FILL;
            cnt <= '0;
          end
        S_FILL:
          if (mem_rd_valid) begin
            cnt <= cnt + 2'd1;
            if (cnt == 2'd3) begin
              st <= S_IDLE;
              vld[set][vway] <= 1'b1;
              drt[set][vway] <= 1'b0;
              plru[set] <= touch(plru[set], vway);
            end
          end
        S_INVAL: begin
          vld[icnt]  <= '0;
          drt[icnt]  <= '0;
          plru[icnt] <= '0;
          icnt <= icnt + 1'b1;
          if (icnt == SET_BITS'(SETS - 1)) begin
            st <= S_IDLE;
            inval_pend <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (cpu_inval) inval_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && cpu_ready && hit && cpu_we) dmem[set][hway][wsel] <= cpu_wdata;
    if (st == S_FILL && mem_rd_valid) begin
      dmem[set][vway][cnt] <= mem_rd_data;
      if (cnt == 2'd3) tags[set][vway] <= tag;
    end
    if (push) begin
      fa[wp] <= push_a;
      fd[wp] <= push_d;
    end
  end

  assert_wr_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_no_fill_over_queued_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !conflict);

  assert_no_answer_in_inval_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !inval_pend);

  assert_wb_hit_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we && !cpu_wt) |=> drt[$past(set)][$past(hway)]);

  assert_wt_store_queued_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we && cpu_wt) |=> (fcnt != '0));
endmodule

// File: tb/dcache_ctrl_test.sv
`timescale 1ns/1ps
module dcache_ctrl_test;
  logic clk, rst_n, cpu_req, cpu_we, cpu_wt, cpu_inval;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic cpu_ready, mem_rd_req, mem_rd_valid, mem_wr_req, mem_wr_ack;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;

  dcache_ctrl uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, fills = 0, wcount = 0;
  logic [31:0] rq[$];
  logic [63:0] wq[$];
  logic [31:0] faddr[$];
  logic [31:0] mem[logic [31:0]];
  logic [31:0] shadow[logic [31:0]];
  logic [7:0] tick = 0;
  string cur = "R1";

  function automatic logic [31:0] init_val(logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] backing(logic [31:0] a);
    return mem.exists(a) ? mem[a] : init_val(a);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  always @(posedge clk) begin
    tick <= tick + 1;
    mem_rd_valid <= rst_n && mem_rd_req && !mem_rd_valid;
    mem_rd_data  <= backing(mem_rd_addr);
    mem_wr_ack   <= rst_n && mem_wr_req && !mem_wr_ack && (tick[3:0] == 4'd0);
  end

  // monitors
  always @(negedge clk) begin
    if (mem_rd_valid) begin
      fills++;
      faddr.push_back(mem_rd_addr);
    end
    if (mem_wr_req && mem_wr_ack) begin
      logic [63:0] e;
      mem[mem_wr_addr] = mem_wr_data;
      wcount++;
      e = (wq.size() != 0) ? wq.pop_front() : 64'hDEAD_DEAD_DEAD_DEAD;
      chk({mem_wr_addr, mem_wr_data} == e, "R9 write order", mem_wr_addr, e[63:32]);
    end
    if (cpu_req && cpu_ready && !cpu_we) begin
      logic [31:0] e;
      e = (rq.size() != 0) ? rq.pop_front() : 32'hDEAD_BEEF;
      chk(cpu_rdata == e, cur, cpu_rdata, e);
    end
  end

  task automatic acc(input bit we, input bit wt, input logic [31:0] a, input logic [31:0] d,
                     output int nf, output int lat);
    int f0;
    @(posedge clk); #1;
    f0 = fills;
    lat = 0;
    if (we) shadow[a] = d;
    else rq.push_back(shadow.exists(a) ? shadow[a] : init_val(a));
    cpu_req = 1; cpu_we = we; cpu_wt = wt; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    while (!cpu_ready) begin
      lat++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    cpu_req = 0;
    nf = fills - f0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (mem_wr_req) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nf, lat, wc0, maxlat;
    clk = 0; rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_wt = 0; cpu_inval = 0;
    cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!cpu_ready && !mem_rd_req && !mem_wr_req, "R1 reset outputs",
        {29'b0, cpu_ready, mem_rd_req, mem_wr_req}, 0);

    // R1/R3: first load misses, refill in order
    cur = "R3 miss data"; faddr.delete();
    acc(0, 0, 32'h8, 0, nf, lat);
    chk(nf == 4, "R1 first access misses", 32'(nf), 4);
    for (int k = 0; k < 4; k++)
      chk(faddr.size() > k && faddr[k] == 32'(k * 4), "R3 refill address order",
          (faddr.size() > k) ? faddr[k] : 32'hFFFF_FFFF, 32'(k * 4));

    // R2: hit in same line
    cur = "R2 hit data";
    acc(0, 0, 32'hC, 0, nf, lat);
    chk(nf == 0, "R2 hit no refill", 32'(nf), 0);
    chk(lat == 0, "R2 hit same cycle", 32'(lat), 0);

    // R5: write-back hit, no memory write
    wc0 = wcount;
    acc(1, 0, 32'h4, 32'h1111_1111, nf, lat);
    repeat (40) @(negedge clk);
    chk(wcount == wc0, "R5 no memory write", 32'(wcount - wc0), 0);
    cur = "R5 updated data";
    acc(0, 0, 32'h4, 0, nf, lat);
    chk(nf == 0, "R5 still a hit", 32'(nf), 0);

    // R4: fill ways 1..3 of set 0 via invalid-first
    cur = "R4 fill data";
    acc(0, 0, 32'h800, 0, nf, lat);  chk(nf == 4, "R4 miss 0x800", 32'(nf), 4);
    acc(0, 0, 32'h1000, 0, nf, lat); chk(nf == 4, "R4 miss 0x1000", 32'(nf), 4);
    acc(0, 0, 32'h1800, 0, nf, lat); chk(nf == 4, "R4 miss 0x1800", 32'(nf), 4);
    chk(wcount == wc0, "R4 invalid ways used first", 32'(wcount - wc0), 0);

    // R7: dirty victim (way 0, line 0x0) written back in order
    wq.push_back({32'h0, init_val(32'h0)});
    wq.push_back({32'h4, 32'h1111_1111});
    wq.push_back({32'h8, init_val(32'h8)});
    wq.push_back({32'hC, init_val(32'hC)});
    cur = "R7 data after eviction";
    acc(0, 0, 32'h2000, 0, nf, lat);
    chk(nf == 4, "R7 refill after eviction", 32'(nf), 4);

    // R10: reload of the evicted line waits for its queued words
    cur = "R10 load sees queued victim data";
    acc(0, 0, 32'h4, 0, nf, lat);
    chk(nf == 4, "R10 refill of evicted line", 32'(nf), 4);
    chk(wcount - wc0 == 4, "R7 four victim words", 32'(wcount - wc0), 4);

    // R4: pseudo-LRU picked way 2 (0x1000), not 0x800
    cur = "R4 hit data";
    acc(0, 0, 32'h800, 0, nf, lat);  chk(nf == 0, "R4 0x800 kept", 32'(nf), 0);
    acc(0, 0, 32'h1800, 0, nf, lat); chk(nf == 0, "R4 0x1800 kept", 32'(nf), 0);
    acc(0, 0, 32'h1000, 0, nf, lat); chk(nf == 4, "R4 0x1000 was victim", 32'(nf), 4);

    // R8: write-through hit
    wq.push_back({32'h808, 32'h2222_2222});
    acc(1, 1, 32'h808, 32'h2222_2222, nf, lat);
    cur = "R8 write-through hit data";
    acc(0, 0, 32'h808, 0, nf, lat);
    chk(nf == 0, "R8 hit line kept", 32'(nf), 0);
    drain();
    chk(backing(32'h808) == 32'h2222_2222, "R8 memory updated", backing(32'h808), 32'h2222_2222);

    // R8/R10: write-through miss, no allocate, load waits for queue
    wq.push_back({32'h3004, 32'h3333_3333});
    acc(1, 1, 32'h3004, 32'h3333_3333, nf, lat);
    chk(nf == 0, "R8 store miss no refill", 32'(nf), 0);
    cur = "R10 load after queued store";
    acc(0, 0, 32'h3004, 0, nf, lat);
    chk(nf == 4, "R8 store miss did not allocate", 32'(nf), 4);
    drain();

    // R9: queue fills and stalls, order kept
    maxlat = 0;
    for (int k = 0; k < 6; k++) begin
      wq.push_back({32'h5000 + 32'(k * 4), 32'h5500 + 32'(k)});
      acc(1, 1, 32'h5000 + 32'(k * 4), 32'h5500 + 32'(k), nf, lat);
      if (lat > maxlat) maxlat = lat;
    end
    chk(maxlat >= 1, "R9 store stalls on full queue", 32'(maxlat), 1);
    drain();
    chk(backing(32'h5014) == 32'h5505, "R9 last queued word", backing(32'h5014), 32'h5505);

    // R6: write-back store miss allocates, no memory write
    wc0 = wcount;
    acc(1, 0, 32'h14, 32'h4444_4444, nf, lat);
    chk(nf == 4, "R6 store miss refills", 32'(nf), 4);
    cur = "R6 allocated data";
    acc(0, 0, 32'h14, 0, nf, lat); chk(nf == 0, "R6 line present", 32'(nf), 0);
    acc(0, 0, 32'h18, 0, nf, lat); chk(nf == 0, "R6 rest of line", 32'(nf), 0);
    repeat (40) @(negedge clk);
    chk(wcount == wc0, "R6 no memory write", 32'(wcount - wc0), 0);

    // R11: invalidate pass
    drain();
    wc0 = wcount;
    @(posedge clk); #1 cpu_inval = 1;
    @(posedge clk); #1 cpu_inval = 0;
    cur = "R11 data after invalidate";
    acc(0, 0, 32'h808, 0, nf, lat);
    chk(lat >= 128, "R11 stall through pass", 32'(lat), 128);
    chk(nf == 4, "R11 line invalidated", 32'(nf), 4);
    shadow.delete(32'h14);
    cur = "R11 dirty data discarded";
    acc(0, 0, 32'h14, 0, nf, lat);
    chk(nf == 4, "R11 dirty line invalidated", 32'(nf), 4);
    repeat (40) @(negedge clk);
    chk(wcount == wc0, "R11 no write-back on invalidate", 32'(wcount - wc0), 0);

    drain();
    chk(wq.size() == 0, "R9 every expected write seen", 32'(wq.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule